// File: doc/BRIEF.md
# Two-Wire Bus Read Master

This block is a bus master for a two-wire serial bus that only performs reads. A host pulses a start command to begin a transfer. The block then sends a start condition and the 7-bit device address followed by a read direction bit, and checks that the device acknowledges. After that it clocks in data bytes one at a time. Each finished byte goes into a holding register and raises a ready flag. Reading the register, by pulsing a read strobe, lowers the flag again.

The host decides how long a transfer lasts through the timing of its stop command. If stop is given in the same cycle as start, exactly one byte is read. Otherwise the host gives stop after it has read the next-to-last byte. The master then answers the following byte with a not-acknowledge and closes the bus with a stop condition. If the host is slow to read, the master holds the clock line low before the acknowledge pulse of the next byte, so no byte is ever overwritten. Both lines are open-drain: an output-enable of 1 pulls the line low, and 0 releases it to the pull-up.

Top module: `i2c_rd_master`

## Requirements
- R1: After reset both output-enables are 0, xfer_done is 1, and rx_ready and nack_flag are 0.
- R2: When a start command is accepted, the master sends a start condition and then 8 bits, most significant bit first. The first 7 bits are dev_addr and the 8th bit is 1, meaning read.
- R3: One SCL period is 4*(clk_div+1) clock cycles, and SCL is high for 2*(clk_div+1) of them. SDA changes while SCL is high only to form a start condition (SDA falling) or a stop condition (SDA rising).
- R4: On the 9th pulse after the address, the master releases SDA and samples it. If SDA is high, nack_flag is set, no data is received, and a stop condition follows, after which xfer_done is 1. The next accepted start clears nack_flag.
- R5: Data bits are taken MSB first. Every received byte except the last is acknowledged by driving SDA low on the 9th pulse. The last byte is left unacknowledged and is followed by a stop condition.
- R6: A completed byte is placed on rx_data and rx_ready is set. rx_ready falls only in the cycle after a rd_strobe, and rx_data does not change while rx_ready stays high.
- R7: A start command and a stop command given in the same cycle give a transfer of exactly one byte.
- R8: A stop command given after the next-to-last byte has been read makes the next byte the last one.
- R9: xfer_done goes low when a start is accepted. It stays low until the stop condition has finished, and then it is high.
- R10: While a finished byte waits for rx_ready to clear, SCL is held low. Reception resumes after the read, and no byte is lost.
- R11: A start command given while a transfer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_start | input | 1 | Start command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| dev_addr | input | 7 | Device address, sampled when a start is accepted |
| clk_div | input | DIVW | Quarter-period divider; one quarter lasts clk_div+1 cycles |
| rd_strobe | input | 1 | Read of the holding register; clears rx_ready |
| rx_data | output | 8 | Holding register |
| rx_ready | output | 1 | A byte is waiting in rx_data |
| nack_flag | output | 1 | The device did not acknowledge its address |
| xfer_done | output | 1 | No transfer is in progress |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A wrong bit counter or phase counter shows up within one byte time: the device model then captures a wrong address byte, or the number of bytes it sends or the acknowledge it sees for the last byte is wrong. A wrong termination decision shows up at the end of the transfer as one byte too many or too few, which leaves expected bytes in the queue or produces an unexpected byte. A lost or overwritten byte shows up as a data mismatch at the next read. Hold behaviour is checked mid-transfer by looking at scl_oe while the host deliberately delays its read.

// File: rtl/i2c_rd_master.sv
`timescale 1ns/1ps
module i2c_rd_master #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_start,
  input  logic            cmd_stop,
  input  logic [6:0]      dev_addr,
  input  logic [DIVW-1:0] clk_div,
  input  logic            rd_strobe,
  output logic [7:0]      rx_data,
  output logic            rx_ready,
  output logic            nack_flag,
  output logic            xfer_done,
  input  logic            sda_in,
  output logic            scl_oe,
  output logic            sda_oe
);

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_ABIT  = 3'd2,
    S_AACK  = 3'd3,
    S_RBIT  = 3'd4,
    S_LOAD  = 3'd5,
    S_DACK  = 3'd6,
    S_STOP  = 3'd7
  } st_t;

  st_t            st;
  logic [DIVW-1:0] cnt;
  logic [1:0]     ph;
  logic [2:0]     bitn;
  logic [7:0]     sh;
  logic           stop_pend;
  logic           ack_lo;
  logic           a_nack;

  wire running = (st != S_IDLE) && (st != S_LOAD);
  wire tick    = running && (cnt == clk_div);
  wire smp     = tick && (ph == 2'd1);
  wire last_ph = tick && (ph == 2'd3);
  wire bit_lo  = (ph == 2'd0) || (ph == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ph  <= 2'd0;
    end else if (!running || tick) begin
      cnt <= '0;
      ph  <= running ? ph + 2'd1 : 2'd0;
    end else begin
      cnt <= cnt + DIVW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      bitn      <= 3'd0;
      sh        <= 8'd0;
      stop_pend <= 1'b0;
      ack_lo    <= 1'b0;
      a_nack    <= 1'b0;
      rx_data   <= 8'd0;
      rx_ready  <= 1'b0;
      nack_flag <= 1'b0;
      xfer_done <= 1'b1;
    end else begin
      if (rd_strobe) rx_ready <= 1'b0;
      if (cmd_stop && st != S_IDLE) stop_pend <= 1'b1;
      case (st)
        S_IDLE: if (cmd_start) begin
          st        <= S_START;
          sh        <= {dev_addr, 1'b1};
          bitn      <= 3'd0;
          stop_pend <= cmd_stop;
          nack_flag <= 1'b0;
          xfer_done <= 1'b0;
        end
        S_START: if (last_ph) st <= S_ABIT;
        S_ABIT: if (last_ph) begin
          sh   <= {sh[6:0], 1'b0};
          bitn <= bitn + 3'd1;
          if (bitn == 3'd7) st <= S_AACK;
        end
        S_AACK: begin
          if (smp) a_nack <= sda_in;
          if (last_ph) begin
            if (a_nack) begin
              nack_flag <= 1'b1;
              st        <= S_STOP;
            end else begin
              st <= S_RBIT;
            end
          end
        end
        S_RBIT: begin
          if (smp) sh <= {sh[6:0], sda_in};
          if (last_ph) begin
            bitn <= bitn + 3'd1;
            if (bitn == 3'd7) st <= S_LOAD;
          end
        end
        S_LOAD: if (!rx_ready) begin
          rx_data  <= sh;
          rx_ready <= 1'b1;
          ack_lo   <= !(stop_pend || cmd_stop);
          st       <= S_DACK;
        end
        S_DACK: if (last_ph) st <= ack_lo ? S_RBIT : S_STOP;
        S_STOP: if (last_ph) begin
          st        <= S_IDLE;
          xfer_done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      S_START: begin
        scl_oe = (ph == 2'd3);
        sda_oe = (ph != 2'd0);
      end
      S_ABIT: begin
        scl_oe = bit_lo;
        sda_oe = !sh[7];
      end
      S_AACK, S_RBIT: scl_oe = bit_lo;
      S_LOAD: scl_oe = 1'b1;
      S_DACK: begin
        scl_oe = bit_lo;
        sda_oe = ack_lo;
      end
      S_STOP: begin
        scl_oe = (ph == 2'd0);
        sda_oe = (ph < 2'd2);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/i2c_rd_master_chk.sv
`timescale 1ns/1ps
module i2c_rd_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_strobe,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       rx_ready,
  input logic       nack_flag,
  input logic       xfer_done,
  input logic [7:0] rx_data,
  input logic [2:0] st_v
);
  localparam logic [2:0] ST_IDLE  = 3'd0;
  localparam logic [2:0] ST_START = 3'd1;
  localparam logic [2:0] ST_LOAD  = 3'd5;
  localparam logic [2:0] ST_STOP  = 3'd7;

  // R6
  rdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ready) |-> $past(rd_strobe));

  // R6
  data_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && $past(rx_ready)) |-> $stable(rx_data));

  // R3
  sda_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && $rose(sda_oe)) |-> (st_v == ST_START));

  // R3
  sda_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && $fell(sda_oe)) |-> (st_v == ST_STOP));

  // R9
  done_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_v != ST_IDLE) |-> !xfer_done);

  // R10
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_v == ST_LOAD) |-> scl_oe);

  // R4
  nack_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack_flag |-> (st_v == ST_STOP || st_v == ST_IDLE));
endmodule

bind i2c_rd_master i2c_rd_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .scl_oe(scl_oe),
  .sda_oe(sda_oe), .rx_ready(rx_ready), .nack_flag(nack_flag),
  .xfer_done(xfer_done), .rx_data(rx_data), .st_v(st)
);

// File: tb/i2c_rd_master_tb_top.sv
`timescale 1ns/1ps
module i2c_rd_master_tb_top;
  localparam logic [6:0] SLV_ADDR = 7'h52;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       cmd_start = 1'b0, drv_stop = 1'b0, mon_stop = 1'b0, mon_rd = 1'b0;
  logic       cmd_stop;
  logic [6:0] dev_addr = 7'd0;
  logic [7:0] clk_div = 8'd3;
  logic [7:0] rx_data;
  logic       rx_ready, nack_flag, xfer_done, scl_oe, sda_oe;
  logic       slv_drv = 1'b0;
  logic       sda_line, scl_line;

  assign cmd_stop = drv_stop | mon_stop;
  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe | slv_drv);

  i2c_rd_master #(.DIVW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .dev_addr(dev_addr), .clk_div(clk_div), .rd_strobe(mon_rd),
    .rx_data(rx_data), .rx_ready(rx_ready), .nack_flag(nack_flag),
    .xfer_done(xfer_done), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];

  task automatic chkv(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // device model
  logic [7:0] slv_base = 8'd0;
  logic [7:0] slv_addr_seen = 8'd0;
  logic [7:0] s_a, s_b;
  int         slv_sent = 0;
  bit         slv_last_mack = 1'b1;
  bit         s_mack;

  initial begin
    forever begin
      forever begin
        @(negedge sda_line);
        if (scl_line === 1'b1) break;
      end
      slv_sent = 0;
      s_a = 8'd0;
      for (int i = 0; i < 8; i++) begin
        @(posedge scl_line);
        s_a = {s_a[6:0], sda_line};
      end
      slv_addr_seen = s_a;
      @(negedge scl_line);
      if (s_a[7:1] == SLV_ADDR && s_a[0]) begin
        slv_drv = 1'b1;
        @(negedge scl_line);
        s_mack = 1'b1;
        while (s_mack) begin
          s_b = slv_base + 8'(slv_sent);
          for (int i = 7; i >= 0; i--) begin
            slv_drv = !s_b[i];
            @(negedge scl_line);
          end
          slv_drv = 1'b0;
          slv_sent++;
          @(posedge scl_line);
          s_mack = !sda_line;
          slv_last_mack = s_mack;
          @(negedge scl_line);
        end
      end
    end
  end

  // SCL high-time monitor
  int hi_cnt = 0;
  int last_hi = 0;
  always @(posedge clk) begin
    if (scl_line === 1'b1) hi_cnt++;
    else begin
      if (hi_cnt != 0) last_hi = hi_cnt;
      hi_cnt = 0;
    end
  end

  // host-side monitor: pops expected bytes and reads the register
  int mon_delay = 0;
  int n_target = 0;
  int idx = 0;
  logic [7:0] e_byte;

  initial begin
    forever begin
      @(negedge clk);
      if (rx_ready) begin
        repeat (mon_delay) @(negedge clk);
        if (mon_delay >= 300 && idx < n_target - 1) begin
          chkv("R10 scl held low while byte waits", scl_oe, 1);
          chkv("R6 ready kept until read", rx_ready, 1);
        end
        if (exp_q.size() == 0) begin
          total++;
          bad++;
          $display("FAIL R6: unexpected byte actual=%0h expected=none", rx_data);
        end else begin
          e_byte = exp_q.pop_front();
          chkv("R6 received byte", rx_data, e_byte);
        end
        mon_rd = 1'b1;
        mon_stop = (idx == n_target - 2);
        idx++;
        @(negedge clk);
        mon_rd = 1'b0;
        mon_stop = 1'b0;
        chkv("R6 ready cleared by read", rx_ready, 0);
      end
    end
  end

  // driver: pushes expected bytes and issues the commands
  task automatic do_read(input logic [6:0] a, input int n, input int dly,
                         input logic [7:0] base, input logic [7:0] div, input bit poke);
    bit hit;
    int t;
    hit = (a == SLV_ADDR);
    @(negedge clk);
    clk_div = div;
    slv_base = base;
    mon_delay = dly;
    n_target = n;
    idx = 0;
    if (hit) for (int k = 0; k < n; k++) exp_q.push_back(base + 8'(k));
    dev_addr = a;
    cmd_start = 1'b1;
    drv_stop = (n == 1);
    @(negedge clk);
    cmd_start = 1'b0;
    drv_stop = 1'b0;
    @(negedge clk);
    chkv("R9 done low while busy", xfer_done, 0);
    chkv("R4 nack cleared by new start", nack_flag, 0);
    if (poke) begin
      repeat (60) @(negedge clk);
      dev_addr = 7'h11;
      cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      dev_addr = a;
    end
    t = 0;
    while (!xfer_done && t < 60000) begin @(negedge clk); t++; end
    t = 0;
    while (exp_q.size() != 0 && t < 2000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    chkv("R2 address and read bit", slv_addr_seen, {a, 1'b1});
    chkv("R9 done after stop", xfer_done, 1);
    if (hit) begin
      if (n == 1) chkv("R7 single byte read", slv_sent, 1);
      else        chkv("R8 byte count set by late stop", slv_sent, n);
      chkv("R5 last byte not acknowledged", slv_last_mack, 0);
      chkv("R5 all expected bytes seen", exp_q.size(), 0);
      chkv("R4 no nack on acknowledged address", nack_flag, 0);
      chkv("R3 scl high time", last_hi, 2 * (int'(div) + 1));
      if (poke) chkv("R11 start while busy ignored", slv_sent, n);
    end else begin
      chkv("R4 nack flag set", nack_flag, 1);
      chkv("R4 no data after nack", rx_ready, 0);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chkv("R1 reset done flag", xfer_done, 1);
    chkv("R1 reset ready", rx_ready, 0);
    chkv("R1 reset nack", nack_flag, 0);
    chkv("R1 reset scl released", scl_oe, 0);
    chkv("R1 reset sda released", sda_oe, 0);

    do_read(SLV_ADDR, 1, 2, 8'hA5, 8'd3, 1'b0);
    do_read(SLV_ADDR, 4, 1, 8'h3C, 8'd3, 1'b0);
    do_read(SLV_ADDR, 3, 0, 8'hF0, 8'd1, 1'b0);
    do_read(SLV_ADDR, 2, 3, 8'h7E, 8'd0, 1'b0);
    do_read(SLV_ADDR, 3, 400, 8'h81, 8'd3, 1'b0);
    do_read(7'h11, 2, 0, 8'h00, 8'd2, 1'b0);
    do_read(SLV_ADDR, 2, 1, 8'h5A, 8'd2, 1'b0);
    do_read(SLV_ADDR, 2, 1, 8'hC3, 8'd3, 1'b1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule